// File: doc/BRIEF.md
# SDRAM Clock-Suspend CKE Sequencer

This block is the controller-side logic that pauses an SDRAM inside a read or write burst by pulling its clock-enable line low, and later lets it run again. The memory stops its internal clock on the edge after it samples CKE low. It keeps its burst position, so the controller must freeze its own beat counter and read-capture logic for those same edges. It must also send no command while the device is paused, and for a fixed recovery time after CKE returns high.

The memory does not refresh itself while it is paused. For this reason the sequencer limits how long CKE may stay low. It ends the pause early when a duration limit is reached or when the refresh logic reports that a refresh is due. After such a forced end it will not pause the device again until the requester has withdrawn its request. A request made outside a burst, during recovery or while a refresh is due is ignored.

Top module: `cke_suspend_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `cke` is 1 and `cmd_stall`, `pipe_hold` and `force_exit` are 0.
- R2: On a clock edge that samples `sus_req`=1 and `burst_active`=1 and `refresh_due`=0 while the sequencer is running, `cke` goes to 0 and `cmd_stall` goes to 1 after that edge.
- R3: A request sampled with `burst_active`=0, or with `refresh_due`=1, is ignored: `cke` stays 1 and `cmd_stall` stays 0.
- R4: `cke` stays 0 while `sus_req` is sampled 1. It returns to 1 after the first edge that samples `sus_req`=0, so a request held for L edges (L < MAX_SUSP_CYC) gives exactly L cycles of `cke`=0.
- R5: `cmd_stall` is 1 in every cycle where `cke` is 0, and for exactly T_CKA_CYC+1 cycles after `cke` returns to 1.
- R6: `cke` stays 0 for at most MAX_SUSP_CYC consecutive cycles. Reaching that count ends the pause and raises `force_exit` for one cycle, the first cycle with `cke`=1.
- R7: An edge that samples `refresh_due`=1 during a pause sets `cke` to 1 at once and pulses `force_exit` for one cycle.
- R8: With HOLD_ALIGN_DEVICE=1, `pipe_hold` is 1 in exactly the cycles that follow an edge at which `cke` was 0. It is therefore high for as many cycles as `cke` was low, starting one cycle later.
- R9: After a forced exit, no new pause begins until `sus_req` has been sampled 0.
- R10: A request during recovery is ignored. When the request is held, the next pause starts T_CKA_CYC+2 cycles after `cke` rose.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| sus_req | input | 1 | Request to pause the device (level) |
| burst_active | input | 1 | A read or write burst is in progress |
| refresh_due | input | 1 | Refresh deadline reached; pause must end |
| cke | output | 1 | Clock-enable to the SDRAM, registered |
| cmd_stall | output | 1 | Blocks command issue during pause and recovery |
| pipe_hold | output | 1 | Freezes beat counter and read capture |
| force_exit | output | 1 | One-cycle pulse when a pause was ended by limit or refresh |

## Verification
Count the edge at which the request is first sampled as edge 1. After that edge, `cke` falls and `cmd_stall` rises in the same cycle. `pipe_hold` follows one edge later. `cke` rises after the edge that samples the end condition, and `force_exit` rises with it. `cmd_stall` drops T_CKA_CYC+1 cycles after that. The bench drives its inputs on the falling edge and samples the outputs on the same falling edge, so every value it reads was settled by the preceding rising edge. In each scenario it records the cycle index of the fall and of the rise, and counts the low, stall, hold and pulse cycles. It compares them with values computed from the request length, the refresh arrival cycle, MAX_SUSP_CYC and T_CKA_CYC.

// File: rtl/cke_sus_pkg.sv
package cke_sus_pkg;

   typedef enum logic [1:0] {
      ST_RUN   = 2'd0,
      ST_SUSP  = 2'd1,
      ST_RECOV = 2'd2
   } sus_state_t;

endpackage

// File: rtl/cke_sus_window.sv
// Counts consecutive paused cycles and flags the last allowed one.
module cke_sus_window #(
   parameter int LIMIT = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_en,
   output logic limit_hit
);
   localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run_en) begin
         cnt_q <= '0;
      end else if (cnt_q != LAST) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign limit_hit = run_en && (cnt_q == LAST);

   // the sequencer must leave the paused state right after the limit
   p_limit_leaves_r6: assert property (@(posedge clk) disable iff (!rst_n)
      limit_hit |=> !run_en);

endmodule

// File: rtl/cke_recov_timer.sv
// Loaded on each exit; reports when the post-exit recovery has elapsed.
module cke_recov_timer #(
   parameter int T_CKA = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic done
);
   localparam int RW = (T_CKA < 1) ? 1 : $clog2(T_CKA + 1);
   localparam logic [RW-1:0] RELOAD = RW'(T_CKA);

   logic [RW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= RELOAD;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign done = (cnt_q == '0);

   // a fresh load with nonzero recovery must not report done at once
   p_load_not_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (load && (T_CKA > 0)) |=> !done);

endmodule

// File: rtl/cke_sus_fsm.sv
// Run / pause / recover sequencing and the registered CKE level.
module cke_sus_fsm
   import cke_sus_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sus_req,
   input  logic       burst_active,
   input  logic       refresh_due,
   input  logic       limit_hit,
   input  logic       recov_done,
   output sus_state_t state_o,
   output logic       cke_o,
   output logic       exit_o,
   output logic       force_o
);
   sus_state_t state_q;
   logic       cke_q;
   logic       force_q;
   logic       rearm_q;
   logic       must_end;
   logic       may_enter;

   assign must_end  = limit_hit || refresh_due;
   assign may_enter = sus_req && burst_active && !refresh_due && !rearm_q;
   assign exit_o    = (state_q == ST_SUSP) && (must_end || !sus_req);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_RUN;
         cke_q   <= 1'b1;
         force_q <= 1'b0;
         rearm_q <= 1'b0;
      end else begin
         force_q <= 1'b0;
         if (!sus_req) begin
            rearm_q <= 1'b0;
         end
         unique case (state_q)
            ST_RUN: begin
               if (may_enter) begin
                  state_q <= ST_SUSP;
                  cke_q   <= 1'b0;
               end
            end
            ST_SUSP: begin
               if (must_end) begin
                  state_q <= ST_RECOV;
                  cke_q   <= 1'b1;
                  force_q <= 1'b1;
                  rearm_q <= sus_req;
               end else if (!sus_req) begin
                  state_q <= ST_RECOV;
                  cke_q   <= 1'b1;
               end
            end
            ST_RECOV: begin
               if (recov_done) begin
                  state_q <= ST_RUN;
               end
            end
            default: begin
               state_q <= ST_RUN;
               cke_q   <= 1'b1;
            end
         endcase
      end
   end

   assign state_o = state_q;
   assign cke_o   = cke_q;
   assign force_o = force_q;

   // a pause is only entered from a qualified request
   p_entry_qualified_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cke_q) |-> $past(sus_req && burst_active && !refresh_due));

   // a refresh deadline ends a pause on the very next edge
   p_refresh_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke_q && refresh_due) |=> cke_q);

   // the forced-exit flag marks the first cycle with CKE high again
   p_force_on_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      force_q |-> $rose(cke_q));

   p_force_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      force_q |=> !force_q);

endmodule

// File: rtl/cke_suspend_seq.sv
module cke_suspend_seq
   import cke_sus_pkg::*;
#(
   parameter int MAX_SUSP_CYC      = 1024,
   parameter int T_CKA_CYC         = 1,
   parameter bit HOLD_ALIGN_DEVICE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sus_req,
   input  logic burst_active,
   input  logic refresh_due,
   output logic cke,
   output logic cmd_stall,
   output logic pipe_hold,
   output logic force_exit
);
   generate
      if (MAX_SUSP_CYC < 2) begin : g_bad_limit
         $error("MAX_SUSP_CYC must be at least 2");
      end
      if (T_CKA_CYC < 0) begin : g_bad_recov
         $error("T_CKA_CYC must not be negative");
      end
   endgenerate

   sus_state_t state_w;
   logic       cke_w;
   logic       limit_w;
   logic       done_w;
   logic       exit_w;
   logic       force_w;

   cke_sus_window #(.LIMIT(MAX_SUSP_CYC)) u_window (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_en    (state_w == ST_SUSP),
      .limit_hit (limit_w)
   );

   cke_recov_timer #(.T_CKA(T_CKA_CYC)) u_recov (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (exit_w),
      .done  (done_w)
   );

   cke_sus_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .sus_req      (sus_req),
      .burst_active (burst_active),
      .refresh_due  (refresh_due),
      .limit_hit    (limit_w),
      .recov_done   (done_w),
      .state_o      (state_w),
      .cke_o        (cke_w),
      .exit_o       (exit_w),
      .force_o      (force_w)
   );

   assign cke        = cke_w;
   assign cmd_stall  = (state_w != ST_RUN);
   assign force_exit = force_w;

   generate
      if (HOLD_ALIGN_DEVICE) begin : g_hold_dev
         logic hold_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hold_q <= 1'b0;
            else        hold_q <= !cke_w;
         end
         assign pipe_hold = hold_q;
      end else begin : g_hold_early
         assign pipe_hold = !cke_w;
      end
   endgenerate

   // commands are blocked whenever the device may be paused
   p_stall_while_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !cke |-> cmd_stall);

   p_stall_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cke) |-> cmd_stall);

   // pipeline freeze never happens while commands flow
   p_hold_in_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pipe_hold |-> cmd_stall);

endmodule

// File: tb/cke_suspend_seq_bench.sv
module cke_suspend_seq_bench;
   localparam int CLK_PERIOD = 10;
   localparam int MAXS       = 6;
   localparam int TCKA       = 2;
   localparam int WATCHDOG   = 50000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sus_req = 1'b0;
   logic burst_active = 1'b0;
   logic refresh_due = 1'b0;
   logic cke, cmd_stall, pipe_hold, force_exit;

   int n_checks = 0;
   int n_fails  = 0;
   int cyc      = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   cke_suspend_seq #(
      .MAX_SUSP_CYC(MAXS), .T_CKA_CYC(TCKA), .HOLD_ALIGN_DEVICE(1'b1)
   ) u_cke_suspend_seq (
      .clk(clk), .rst_n(rst_n), .sus_req(sus_req), .burst_active(burst_active),
      .refresh_due(refresh_due), .cke(cke), .cmd_stall(cmd_stall),
      .pipe_hold(pipe_hold), .force_exit(force_exit)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int imin(input int a, input int b);
      return (a < b) ? a : b;
   endfunction

   // Drives a request of req_len edges; refresh_due from index ref_at (-1: never).
   task automatic run_case(input int req_len, input int ref_at, input bit burst, input string tag);
      int w = req_len + MAXS + TCKA + 8;
      int lowc = 0, stallc = 0, holdc = 0, forcec = 0, falls = 0;
      int fall_at = -1, rise_at = -1;
      int prev = 1;
      int e_low, e_force;
      burst_active = burst;
      for (int k = 0; k <= w; k++) begin
         @(negedge clk);
         if (k > 0) begin
            if (!cke) lowc++;
            if (cmd_stall) stallc++;
            if (pipe_hold) holdc++;
            if (force_exit) forcec++;
            if (prev == 1 && !cke) begin
               falls++;
               if (fall_at < 0) fall_at = k;
            end
            if (prev == 0 && cke && rise_at < 0) rise_at = k;
            prev = cke;
         end
         sus_req     = (k < req_len);
         refresh_due = (ref_at >= 0) && (k >= ref_at) && (k < w - 2);
      end
      sus_req = 1'b0; refresh_due = 1'b0; burst_active = 1'b0;
      repeat (TCKA + 4) @(negedge clk);
      if (!burst || ref_at == 0 || req_len == 0) begin
         e_low = 0; e_force = 0;
      end else begin
         e_low   = imin(req_len, MAXS);
         e_force = (req_len >= MAXS) ? 1 : 0;
         if (ref_at > 0 && ref_at <= e_low) begin
            e_low   = ref_at;
            e_force = 1;
         end
      end
      chk(e_low < MAXS ? "R4" : "R6", {tag, " cke low cycles"}, lowc, e_low);
      chk("R5", {tag, " stall cycles"}, stallc, (e_low > 0) ? e_low + TCKA + 1 : 0);
      chk("R8", {tag, " hold cycles"}, holdc, e_low);
      chk(ref_at > 0 ? "R7" : "R6", {tag, " force pulses"}, forcec, e_force);
      chk("R9", {tag, " pause entries"}, falls, (e_low > 0) ? 1 : 0);
      if (e_low > 0) begin
         chk("R2", {tag, " fall index"}, fall_at, 1);
         chk("R4", {tag, " rise index"}, rise_at, e_low + 1);
      end else begin
         chk("R3", {tag, " no fall"}, fall_at, -1);
      end
   endtask

   // R10: request withdrawn for one edge, then reasserted during recovery
   task automatic run_reentry();
      int w = TCKA + 20;
      int fall2 = -1, rise1 = -1, falls = 0, prev = 1, lowc = 0;
      burst_active = 1'b1;
      for (int k = 0; k <= w; k++) begin
         @(negedge clk);
         if (k > 0) begin
            if (!cke) lowc++;
            if (prev == 1 && !cke) begin
               falls++;
               if (falls == 2) fall2 = k;
            end
            if (prev == 0 && cke && rise1 < 0) rise1 = k;
            prev = cke;
         end
         sus_req = (k < 2) || (k >= 3 && k < TCKA + 9);
      end
      sus_req = 1'b0; burst_active = 1'b0;
      repeat (TCKA + 4) @(negedge clk);
      chk("R10", "reentry entries", falls, 2);
      chk("R10", "reentry first rise", rise1, 3);
      chk("R10", "reentry second fall", fall2, TCKA + 5);
      chk("R4", "reentry total low", lowc, 7);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc >= WATCHDOG && !finished) begin
         n_fails++;
         $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cyc, WATCHDOG);
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", "reset cke", int'(cke), 1);
      chk("R1", "reset stall", int'(cmd_stall), 0);
      chk("R1", "reset hold", int'(pipe_hold), 0);
      chk("R1", "reset force", int'(force_exit), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "post-reset cke", int'(cke), 1);
      chk("R1", "post-reset stall", int'(cmd_stall), 0);

      for (int len = 0; len <= MAXS + TCKA + 4; len++) begin
         run_case(len, -1, 1'b1, $sformatf("len=%0d", len));
      end
      run_case(3, -1, 1'b0, "no-burst short");
      run_case(MAXS + 1, -1, 1'b0, "no-burst long");
      run_case(3, 0, 1'b1, "refresh blocks entry");
      for (int r = 1; r <= MAXS; r++) begin
         run_case(MAXS + TCKA + 4, r, 1'b1, $sformatf("refresh@%0d", r));
      end
      run_reentry();

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

endmodule